// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block is a read-only, direct-mapped cache whose line array is split into two equal halves. Each address has a home slot, chosen by its index bits, and a partner slot: the same set in the other half, reached by inverting the top index bit. A lookup first probes the home slot. A match there is a fast hit, answered one cycle after the request is accepted. On a mismatch the controller spends one more cycle probing the partner slot. A match there is a slow hit, answered two cycles after acceptance. Lower memory is asked for the line only when both probes miss. The result is close to the conflict-miss rate of a two-way cache, while the common case keeps a direct-mapped hit path.

After a slow hit, the two slots trade contents, so the line just used now sits in its home slot. On a full miss, the home slot's previous line moves to the partner slot and the fetched line is installed at home. Whatever the partner slot held before is dropped. Each stored key carries the top index bit along with the tag, so a line parked in its partner slot can never be taken for a line whose home is that slot.

The controller has three states. IDLE accepts a request and probes the home slot. ALT_PROBE probes the partner slot. FETCH holds the memory request until fill data returns. The transitions are:
- IDLE to IDLE on a fast hit or when no request is present.
- IDLE to ALT_PROBE on a home miss.
- ALT_PROBE to IDLE on a slow hit, with the swap.
- ALT_PROBE to FETCH when both probes miss.
- FETCH to FETCH while waiting for data.
- FETCH to IDLE when fill data arrives, with the install.

Top module: `pac_cache`

## Requirements
- R1: After reset, every line is invalid. `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first read of any address therefore goes to memory.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. If the home slot (index = `req_addr[IDX_W-1:0]`) holds the address, `rsp_valid` is 1 for one cycle right after that edge, with `rsp_kind` = 2'b00 (fast) and the line's data.
- R3: If the home slot misses and the partner slot (the index with bit IDX_W-1 inverted) holds the address, the response follows two edges after acceptance, with `rsp_kind` = 2'b01 (slow).
- R4: After a slow hit, the two slots have exchanged contents. The same address then hits fast, and the line that was displaced from the home slot hits slow.
- R5: When both probes miss, `mem_req_valid` rises in the cycle after the partner probe. `mem_req_addr` carries the request address, and both hold steady until an edge that samples `mem_rsp_valid` = 1. The response follows that edge, with `rsp_kind` = 2'b10 (filled) and `mem_rsp_data` as its data.
- R6: On a fill, the fetched line goes to the home slot and the previous home line moves to the partner slot. The previous partner line is discarded.
- R7: `req_ready` is 0 from the accepting edge until the response is presented. A request held on `req_valid` during that window is not accepted, produces no response and installs nothing.
- R8: `mem_rsp_valid` arriving while no fill is outstanding has no effect on responses or on cache contents.
- R9: A stored key holds `addr[AW-1:IDX_W-1]`. An address whose home slot holds a line parked there from the other half, sharing the bits above the index, is still a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW | Word address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 00 fast hit, 01 slow hit, 10 filled from memory |
| rsp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Line fetch request, held until fill |
| mem_req_addr | output | AW | Address of the line to fetch |
| mem_rsp_valid | input | 1 | Fill data strobe |
| mem_rsp_data | input | DW | Fill data |

## Verification
The two functions that can land on the same clock edge are the two slot writes: a swap, or an eviction together with an install, updates the home and partner slots on one edge, and that is the edge on which the response is registered. A scripted address sequence creates this case on purpose. It alternates two addresses that share a home slot, and it brings in a third address from the other half whose home is the first pair's partner slot. The result of each double write is then judged only through later accesses: their latency kind and their cycle count show where every line ended up. A stray fill strobe sent while idle and a request held through a busy window are also checked through later responses.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ALT_PROBE = 2'd1,
        ST_FETCH     = 2'd2
    } pac_state_e;

    typedef enum logic [1:0] {
        KIND_FAST   = 2'b00,
        KIND_SLOW   = 2'b01,
        KIND_FILLED = 2'b10
    } pac_kind_e;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W = 4,
    parameter int KEY_W = 13,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [KEY_W-1:0] ra_key,
    output logic [DW-1:0]    ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [KEY_W-1:0] rb_key,
    output logic [DW-1:0]    rb_data,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  logic             wa_valid,
    input  logic [KEY_W-1:0] wa_key,
    input  logic [DW-1:0]    wa_data,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic             wb_valid,
    input  logic [KEY_W-1:0] wb_key,
    input  logic [DW-1:0]    wb_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic             v_q [DEPTH];
    logic [KEY_W-1:0] k_q [DEPTH];
    logic [DW-1:0]    d_q [DEPTH];

    // Both write ports may fire on one edge; they always target different slots.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                v_q[i] <= 1'b0;
                k_q[i] <= '0;
                d_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wa_en && wa_idx == IDX_W'(i)) begin
                    v_q[i] <= wa_valid;
                    k_q[i] <= wa_key;
                    d_q[i] <= wa_data;
                end else if (wb_en && wb_idx == IDX_W'(i)) begin
                    v_q[i] <= wb_valid;
                    k_q[i] <= wb_key;
                    d_q[i] <= wb_data;
                end
            end
        end
    end

    assign ra_valid = v_q[ra_idx];
    assign ra_key   = k_q[ra_idx];
    assign ra_data  = d_q[ra_idx];
    assign rb_valid = v_q[rb_idx];
    assign rb_key   = k_q[rb_idx];
    assign rb_data  = d_q[rb_idx];

endmodule

// File: rtl/pac_match.sv
module pac_match #(
    parameter int KEY_W = 13
) (
    input  logic             slot_valid,
    input  logic [KEY_W-1:0] slot_key,
    input  logic [KEY_W-1:0] probe_key,
    output logic             hit
);
    assign hit = slot_valid && (slot_key == probe_key);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      hit_home,
    input  logic      hit_alt,
    input  logic      fill_valid,
    output logic      ready,
    output logic      capture,
    output logic      fetch_active,
    output logic      swap_en,
    output logic      install_en,
    output logic      rsp_fire,
    output pac_kind_e rsp_kind
);
    pac_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        ready        = 1'b0;
        capture      = 1'b0;
        fetch_active = 1'b0;
        swap_en      = 1'b0;
        install_en   = 1'b0;
        rsp_fire     = 1'b0;
        rsp_kind     = KIND_FAST;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (req_valid) begin
                    capture = 1'b1;
                    if (hit_home) begin
                        rsp_fire = 1'b1;
                        rsp_kind = KIND_FAST;
                    end else begin
                        state_d = ST_ALT_PROBE;
                    end
                end
            end
            ST_ALT_PROBE: begin
                if (hit_alt) begin
                    swap_en  = 1'b1;
                    rsp_fire = 1'b1;
                    rsp_kind = KIND_SLOW;
                    state_d  = ST_IDLE;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                fetch_active = 1'b1;
                if (fill_valid) begin
                    install_en = 1'b1;
                    rsp_fire   = 1'b1;
                    rsp_kind   = KIND_FILLED;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pac_cache.sv
module pac_cache
    import pac_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [1:0]    rsp_kind,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int KEY_W = AW - IDX_W + 1;
    localparam logic [IDX_W-1:0] HALF_FLIP = IDX_W'(1) << (IDX_W - 1);

    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    look_addr;
    logic [IDX_W-1:0] home_idx, alt_idx;
    logic [KEY_W-1:0] probe_key;

    logic             ra_valid, rb_valid;
    logic [KEY_W-1:0] ra_key, rb_key;
    logic [DW-1:0]    ra_data, rb_data;
    logic             hit_home, hit_alt;

    logic             ready, capture, fetch_active, swap_en, install_en, rsp_fire;
    pac_kind_e        fire_kind;

    logic             wa_valid;
    logic [KEY_W-1:0] wa_key;
    logic [DW-1:0]    wa_data;

    pac_kind_e        kind_q;
    logic             rsp_valid_q;
    logic [DW-1:0]    rsp_data_q;

    // In IDLE the live request is probed; afterwards the captured one.
    assign look_addr = ready ? req_addr : addr_q;
    assign home_idx  = look_addr[IDX_W-1:0];
    assign alt_idx   = home_idx ^ HALF_FLIP;
    assign probe_key = look_addr[AW-1:IDX_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= req_addr;
    end

    pac_line_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (home_idx),
        .ra_valid (ra_valid),
        .ra_key   (ra_key),
        .ra_data  (ra_data),
        .rb_idx   (alt_idx),
        .rb_valid (rb_valid),
        .rb_key   (rb_key),
        .rb_data  (rb_data),
        .wa_en    (swap_en | install_en),
        .wa_idx   (home_idx),
        .wa_valid (wa_valid),
        .wa_key   (wa_key),
        .wa_data  (wa_data),
        .wb_en    (swap_en | install_en),
        .wb_idx   (alt_idx),
        .wb_valid (ra_valid),
        .wb_key   (ra_key),
        .wb_data  (ra_data)
    );

    pac_match #(.KEY_W(KEY_W)) u_match_home (
        .slot_valid (ra_valid),
        .slot_key   (ra_key),
        .probe_key  (probe_key),
        .hit        (hit_home)
    );

    pac_match #(.KEY_W(KEY_W)) u_match_alt (
        .slot_valid (rb_valid),
        .slot_key   (rb_key),
        .probe_key  (probe_key),
        .hit        (hit_alt)
    );

    pac_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .hit_home     (hit_home),
        .hit_alt      (hit_alt),
        .fill_valid   (mem_rsp_valid),
        .ready        (ready),
        .capture      (capture),
        .fetch_active (fetch_active),
        .swap_en      (swap_en),
        .install_en   (install_en),
        .rsp_fire     (rsp_fire),
        .rsp_kind     (fire_kind)
    );

    // Home slot receives the partner line on a swap, the fetched line on a fill.
    always_comb begin
        if (install_en) begin
            wa_valid = 1'b1;
            wa_key   = probe_key;
            wa_data  = mem_rsp_data;
        end else begin
            wa_valid = rb_valid;
            wa_key   = rb_key;
            wa_data  = rb_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            kind_q      <= KIND_FAST;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rsp_fire;
            if (rsp_fire) begin
                kind_q <= fire_kind;
                unique case (fire_kind)
                    KIND_FAST:   rsp_data_q <= ra_data;
                    KIND_SLOW:   rsp_data_q <= rb_data;
                    KIND_FILLED: rsp_data_q <= mem_rsp_data;
                    default:     rsp_data_q <= '0;
                endcase
            end
        end
    end

    assign req_ready     = ready;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_kind      = kind_q;
    assign rsp_data      = rsp_data_q;
    assign mem_req_valid = fetch_active;
    assign mem_req_addr  = addr_q;

endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_kind,
    input logic          mem_req_valid,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid
);
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((rsp_valid && rsp_kind == 2'b00) || !req_ready));

    assert_slow_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b01) |-> $past(!req_ready));

    assert_fill_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b10) |-> $past(mem_req_valid && mem_rsp_valid));

    assert_memreq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_memreq_after_probe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(!req_ready));

    assert_ready_on_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));

endmodule

bind pac_cache pac_cache_chk #(.AW(AW)) u_pac_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_pac_cache.sv
`timescale 1ns/1ps
module tb_pac_cache;
    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int IDX_W   = 4;
    localparam int MEM_LAT = 2;
    localparam int NVEC    = 14;

    localparam logic [1:0] K_FAST = 2'b00;
    localparam logic [1:0] K_SLOW = 2'b01;
    localparam logic [1:0] K_FILL = 2'b10;

    // Address sequence and expected kind, worked out from R2-R6 and R9.
    localparam logic [AW-1:0] VEC_A [NVEC] = '{
        16'h0005, 16'h0005, 16'h0105, 16'h0005, 16'h0005, 16'h0105, 16'h000D,
        16'h0005, 16'h0105, 16'h000D, 16'h0005, 16'h000D, 16'h0020, 16'h0020};
    localparam logic [1:0] VEC_K [NVEC] = '{
        K_FILL, K_FAST, K_FILL, K_SLOW, K_FAST, K_SLOW, K_FILL,
        K_FAST, K_FILL, K_FILL, K_FAST, K_FAST, K_FILL, K_FAST};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [DW-1:0] rsp_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pac_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_kind      (rsp_kind),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic string kind_tag(input logic [1:0] k);
        if (k == K_FAST) return "R2";
        if (k == K_SLOW) return "R3";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // One read with a behavioural memory of fixed latency MEM_LAT.
    task automatic do_read(input logic [AW-1:0] a, input bit noisy, input logic [AW-1:0] noise_a,
                           output logic [1:0] k, output logic [DW-1:0] d, output int cyc,
                           output bit addr_ok, output bit busy_ok);
        int  wm;
        bit  got;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cyc = 0; wm = 0; got = 0; k = 2'b11; d = '0; addr_ok = 1; busy_ok = 1;
        while (!got && cyc < 40) begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc == 1) begin
                if (noisy) req_addr = noise_a;
                else       req_valid = 1'b0;
            end
            if (cyc == 2) req_valid = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rsp_valid) begin
                got = 1;
                k   = rsp_kind;
                d   = rsp_data;
            end else begin
                if (req_ready) busy_ok = 0;
                if (mem_req_valid) begin
                    if (mem_req_addr != a) addr_ok = 0;
                    wm++;
                    if (wm == MEM_LAT) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_data  = mem_fn(a);
                    end
                end
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic read_and_check(input logic [AW-1:0] a, input logic [1:0] ek, input string tag,
                                  input bit noisy, input logic [AW-1:0] noise_a);
        logic [1:0]    k;
        logic [DW-1:0] d;
        int            cyc;
        bit            aok, bok;
        int            elat;
        do_read(a, noisy, noise_a, k, d, cyc, aok, bok);
        elat = (ek == K_FAST) ? 1 : (ek == K_SLOW) ? 2 : 2 + MEM_LAT;
        chk(k == ek, tag, $sformatf("kind @%h", a), k, ek);
        chk(d == mem_fn(a), kind_tag(ek), $sformatf("data @%h", a), d, mem_fn(a));
        chk(cyc == elat, kind_tag(ek), $sformatf("latency @%h", a), cyc, elat);
        chk(bok, "R7", "ready high while busy", bok, 1);
        if (ek == K_FILL) chk(aok, "R5", "mem_req_addr", aok, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset",
            {req_ready, rsp_valid}, 2'b10);

        // Vector walk: vector 0 is R1 (empty cache), 3 and 5 R3/R4, 6 R9, 7-9 R6.
        for (int i = 0; i < NVEC; i++) begin
            read_and_check(VEC_A[i], VEC_K[i], (i == 6) ? "R9" : (i >= 7 && i <= 9) ? "R6" :
                           (i == 4 || i == 5) ? "R4" : kind_tag(VEC_K[i]), 1'b0, '0);
        end

        // R8: stray fill strobes while idle change nothing.
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hDEAD_BEEF;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1;
            chk(rsp_valid == 1'b0, "R8", "no response to stray fill", rsp_valid, 0);
        end
        mem_rsp_valid = 1'b0;
        read_and_check(16'h0005, K_FAST, "R8", 1'b0, '0);
        read_and_check(16'h000D, K_FAST, "R8", 1'b0, '0);

        // R7: a request held during a miss is neither accepted nor installed.
        read_and_check(16'h0030, K_FILL, "R7", 1'b1, 16'h0044);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1;
            chk(rsp_valid == 1'b0, "R7", "no response to held request", rsp_valid, 0);
        end
        read_and_check(16'h0044, K_FILL, "R7", 1'b0, '0);

        // R6: previous home line of slot 0 now sits in slot 8.
        read_and_check(16'h0020, K_SLOW, "R6", 1'b0, '0);
        read_and_check(16'h0020, K_FAST, "R4", 1'b0, '0);
        read_and_check(16'h0030, K_SLOW, "R4", 1'b0, '0);

        done = 1;
        summary();
        $finish;
    end

endmodule